// File: doc/BRIEF.md
# Static Backward-Taken Branch Predictor

This block sits beside the fetch stage and guesses, without any stored history, whether the conditional branch being fetched will be taken. It looks only at the sign of the branch's 12-bit B-type offset. An offset that points back toward lower addresses is usually a loop-closing branch, so it is predicted taken. An offset that points forward is predicted not taken. Anything that is not flagged as a branch is predicted not taken.

To redirect fetch, the block also forms the taken target in the same cycle. The target is the fetch address plus the sign-extended offset counted in 2-byte units. The logic is purely combinational and holds no state.

An update port, carrying the resolved outcome of earlier branches, is present so that the block can be exchanged with a learning predictor. The block accepts those inputs and does nothing with them.

Top module: `bwd_taken_predictor`

## Requirements
- R1: When `is_branch` is 0, `pred_taken` is 0 whatever the immediate is.
- R2: When `is_branch` is 1 and bit 11 of `br_imm` is 1 (a backward offset), `pred_taken` is 1.
- R3: When `is_branch` is 1 and bit 11 of `br_imm` is 0 (a forward or zero offset), `pred_taken` is 0.
- R4: `pred_target` always equals `fetch_pc` plus `br_imm` sign-extended and shifted left by one bit, modulo 2^32. The target is meaningful only while `pred_taken` is 1.
- R5: At the ends of the offset range the target is exact. An immediate of 0x800 gives `fetch_pc` - 4096, and an immediate of 0x7FF gives `fetch_pc` + 4094.
- R6: Target arithmetic wraps modulo 2^32 when a backward offset is applied to a fetch address near zero.
- R7: `is_jump` has no effect on either output.
- R8: The update inputs have no effect on either output.
- R9: The outputs follow the inputs combinationally, with no clock edge between a change of input and the new prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_pc | input | 32 | Address of the instruction being fetched |
| br_imm | input | 12 | B-type immediate of that instruction, in 2-byte units |
| is_branch | input | 1 | The fetched instruction is a conditional branch |
| is_jump | input | 1 | The fetched instruction is a jump (no effect) |
| upd_valid | input | 1 | Resolved-outcome write strobe (no effect) |
| upd_taken | input | 1 | Resolved taken outcome (no effect) |
| upd_target | input | 32 | Resolved target (no effect) |
| upd_pc | input | 32 | Address of the resolved branch (no effect) |
| upd_backward | input | 1 | Resolved branch direction (no effect) |
| upd_predicted | input | 1 | Prediction originally made (no effect) |
| pred_taken | output | 1 | Taken prediction |
| pred_target | output | 32 | Predicted target, valid while pred_taken is 1 |

## Verification
The ordering checks on the target assume that a backward offset is applied only when the fetch address is at least 4096. They also assume that a forward offset is applied only when the address is at least 4096 below the top of the address space. Outside those ranges the target wraps as intended, so the checks are not applied there. The wraparound stimulus for R6 is deliberately placed outside the first range, where that check stands aside. All other stimulus keeps its fetch addresses inside both ranges. Every fetch address driven is even, which keeps the parity check on the target consistent with real instruction alignment.

// File: rtl/bwd_taken_predictor.sv
module bwd_taken_predictor #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [IMM_W-1:0]  br_imm,
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_backward,
  input  logic              upd_predicted,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target
);

  localparam int EXT_W = ADDR_W - IMM_W - 1;
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(1) << IMM_W;
  localparam logic [ADDR_W-1:0] TOP_OK = {ADDR_W{1'b1}} - SPAN;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;
  logic              taken;

  wire unused_inputs = ^{is_jump, upd_valid, upd_taken, upd_target,
                         upd_pc, upd_backward, upd_predicted};

  always_comb begin
    offset = {{EXT_W{br_imm[IMM_W-1]}}, br_imm, 1'b0};
    target = fetch_pc + offset;
    taken  = is_branch & br_imm[IMM_W-1];

    if (!is_branch) AST_NO_BRANCH_NOT_TAKEN: assert (!taken); // R1
    if (fetch_pc[0] == 1'b0) AST_TARGET_EVEN: assert (target[0] == 1'b0); // R4
    if (taken && fetch_pc >= SPAN) AST_BACKWARD_BELOW_PC: assert (target < fetch_pc); // R2
    if (is_branch && !taken && fetch_pc <= TOP_OK) AST_FORWARD_AT_OR_ABOVE_PC: assert (target >= fetch_pc); // R3
  end

  assign pred_taken  = taken;
  assign pred_target = target;

endmodule

// File: tb/bwd_taken_predictor_tb_top.sv
module bwd_taken_predictor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [11:0] br_imm = '0;
  logic        is_branch = 1'b0;
  logic        is_jump = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [31:0] upd_pc = '0;
  logic        upd_backward = 1'b0;
  logic        upd_predicted = 1'b0;
  logic        pred_taken;
  logic [31:0] pred_target;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bwd_taken_predictor dut_i (
    .fetch_pc(fetch_pc), .br_imm(br_imm), .is_branch(is_branch), .is_jump(is_jump),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_target(upd_target),
    .upd_pc(upd_pc), .upd_backward(upd_backward), .upd_predicted(upd_predicted),
    .pred_taken(pred_taken), .pred_target(pred_target)
  );

  function automatic logic [31:0] ref_target(logic [31:0] pc, logic [11:0] imm);
    int signed o;
    o = $signed(imm);
    return pc + 32'(o * 2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, logic [11:0] imm, logic br, logic jmp);
    @(negedge clk);
    fetch_pc = pc; br_imm = imm; is_branch = br; is_jump = jmp;
    #1;
  endtask

  task automatic t_reset_state;
    check("R1 reset taken", 32'(pred_taken), 32'd0);
    check("R4 reset target", pred_target, 32'd0);
  endtask

  task automatic t_not_branch;
    apply(32'h0000_8000, 12'hFF0, 1'b0, 1'b0);
    check("R1 non-branch backward imm", 32'(pred_taken), 32'd0);
    check("R4 target still formed", pred_target, ref_target(32'h0000_8000, 12'hFF0));
  endtask

  task automatic t_backward;
    apply(32'h0001_0040, 12'hFFE, 1'b1, 1'b0);
    check("R2 backward taken", 32'(pred_taken), 32'd1);
    check("R4 backward target", pred_target, 32'h0001_003C);
    apply(32'h2000_0100, 12'hF80, 1'b1, 1'b0);
    check("R2 backward taken 2", 32'(pred_taken), 32'd1);
    check("R4 backward target 2", pred_target, ref_target(32'h2000_0100, 12'hF80));
  endtask

  task automatic t_forward;
    apply(32'h0001_0040, 12'h010, 1'b1, 1'b0);
    check("R3 forward not taken", 32'(pred_taken), 32'd0);
    check("R4 forward target", pred_target, 32'h0001_0060);
    apply(32'h0001_0040, 12'h000, 1'b1, 1'b0);
    check("R3 zero offset not taken", 32'(pred_taken), 32'd0);
    check("R4 zero offset target", pred_target, 32'h0001_0040);
  endtask

  task automatic t_extremes;
    apply(32'h0040_0000, 12'h800, 1'b1, 1'b0);
    check("R5 min offset taken", 32'(pred_taken), 32'd1);
    check("R5 min offset target", pred_target, 32'h003F_F000);
    apply(32'h0040_0000, 12'h7FF, 1'b1, 1'b0);
    check("R5 max offset not taken", 32'(pred_taken), 32'd0);
    check("R5 max offset target", pred_target, 32'h0040_0FFE);
  endtask

  task automatic t_wrap;
    apply(32'h0000_0004, 12'hFFC, 1'b1, 1'b0);
    check("R6 wrap taken", 32'(pred_taken), 32'd1);
    check("R6 wrap target", pred_target, 32'hFFFF_FFFC);
  endtask

  task automatic t_jump_ignored;
    apply(32'h0000_9000, 12'h010, 1'b0, 1'b1);
    check("R7 jump alone not taken", 32'(pred_taken), 32'd0);
    apply(32'h0000_9000, 12'hFF0, 1'b1, 1'b1);
    check("R7 jump with backward branch", 32'(pred_taken), 32'd1);
    check("R7 jump target", pred_target, 32'h0000_8FE0);
  endtask

  task automatic t_update_ignored;
    apply(32'h0000_A000, 12'h020, 1'b1, 1'b0);
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = 1'b1; upd_target = 32'h1234_5678;
    upd_pc = 32'h0000_A000; upd_backward = 1'b1; upd_predicted = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R8 update no effect taken", 32'(pred_taken), 32'd0);
    check("R8 update no effect target", pred_target, 32'h0000_A040);
    upd_valid = 1'b0; upd_taken = 1'b0; upd_backward = 1'b0; upd_predicted = 1'b0;
  endtask

  task automatic t_combinational;
    @(posedge clk);
    #1;
    fetch_pc = 32'h0000_C000; br_imm = 12'hFFF; is_branch = 1'b1; is_jump = 1'b0;
    #1;
    check("R9 same-cycle taken", 32'(pred_taken), 32'd1);
    check("R9 same-cycle target", pred_target, 32'h0000_BFFE);
    is_branch = 1'b0;
    #1;
    check("R9 same-cycle drop", 32'(pred_taken), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_state();
    t_not_branch();
    t_backward();
    t_forward();
    t_extremes();
    t_wrap();
    t_jump_ignored();
    t_update_ignored();
    t_combinational();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule